// File: doc/BRIEF.md
# Lane-Masked Single-Port RAM with Address Hold

This block is a synchronous single-port memory whose write path is split into equal lanes. Each write-enable lane bit decides whether its slice of the write word reaches the array. A lane that is not enabled keeps what it held. The lane size can be set to 5, 8, 9 or 10 bits, and the word width must be a whole number of lanes.

The address is captured in a register on every enabled clock edge. An address-hold input freezes that register, so reads and writes keep using the address captured earlier. A read-enable input decides whether the read register takes a new value, during a write as well as during a plain read. Same-port read-during-write behaviour is fixed at elaboration by a mode parameter.

An optional output register adds one cycle of latency. An optional asynchronous clear zeroes the output stage. That stage is the output register when one is present, or the read register when it is not. A clock enable gates every update.

Top module: `lanemask_ram`

## Requirements
- R1: Write-mask bit i (wr_lane[i]) controls data bits [i*LANE_W +: LANE_W], so bit 0 controls the least significant lane. A write stores every enabled lane at the selected address. LANE_W must be 5, 8, 9 or 10, and the mask width is DATA_W/LANE_W.
- R2: During a write, lanes whose mask bit is 0 keep their previously stored contents.
- R3: While hold_addr is 1, the address register keeps its value and addr is ignored. The access on that edge, read or write, uses the held address.
- R4: When rd_en is 0 on an enabled edge, the read register keeps its value, including during a write.
- R5: A read (wr_en=0, rd_en=1) places the word stored at the selected address on rdata. With OUT_REG=1 it appears after the second enabled rising edge. With OUT_REG=0 it appears after the first.
- R6: With RDW_MODE=RDW_NEW_MERGED, a write with rd_en=1 returns the new data on enabled lanes and the previously stored data on masked lanes.
- R7: With RDW_MODE=RDW_NEW_MASKED_ZERO, a write with rd_en=1 returns the new data on enabled lanes and zero on masked lanes.
- R8: With RDW_MODE=RDW_OLD_WORD, a write with rd_en=1 returns the word stored before the write. RDW_ANY returns the same value.
- R9: When en is 0, a rising edge changes neither the array, nor the address register, nor the read register, nor the output register.
- R10: With OUT_CLR=1, clr=1 forces rdata to zero at once, without waiting for a clock edge. rdata stays zero while clr is high, and until the next load of the output stage.
- R11: A rising edge with rst_n=0 zeroes rdata, the read register and the address register, and blocks writes. A later held-address access therefore uses address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable for all registers and for the array |
| clr | input | 1 | Asynchronous clear of the output stage, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write word |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read register update enable |
| wr_lane | input | LANES | Per-lane write mask; bit 0 is the least significant lane |
| hold_addr | input | 1 | Address hold; 1 keeps the captured address |
| rdata | output | DATA_W | Read word |

## Verification
The assertions assume that clr, whenever it is raised, stays high across at least one rising clock edge. They also assume that addresses stay below DEPTH, and that a read never returns an address that was never written. The stimulus raises clr between edges and holds it across a full edge before releasing it. Every address it uses gets a full-lane write before any read or masked write, with rd_en kept low on those first writes. A second reset is issued only after address 0 has been written, so the held-address read after it returns a defined word.

// File: rtl/lanemask_ram_pkg.sv
// Shared types for the lane-masked RAM.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lanemask_ram_pkg;
    // Same-port read-during-write behaviour.
    typedef enum logic [1:0] {
        RDW_NEW_MASKED_ZERO = 2'd0,
        RDW_NEW_MERGED      = 2'd1,
        RDW_OLD_WORD        = 2'd2,
        RDW_ANY             = 2'd3
    } rdw_mode_e;
endpackage

// File: rtl/lanemask_ram_addr.sv
// Address capture register with hold.
// Produces the address used on the current edge: the held address while
// hold_addr is 1, otherwise the incoming address. Assumes synchronous reset.
module lanemask_ram_addr #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hold_addr,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] use_addr
);
    logic [ADDR_W-1:0] addr_q;

    // Select the held address or the incoming one for this edge.
    assign use_addr = hold_addr ? addr_q : addr;

    // Capture the address used on every enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (en) begin
            addr_q <= use_addr;
        end
    end

    // R3: a held edge leaves the captured address unchanged.
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold_addr) |=> $stable(addr_q));

    // R9: an idle edge leaves the captured address unchanged.
    p_addr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(addr_q));
endmodule

// File: rtl/lanemask_ram_array.sv
// Storage array split into one memory per lane.
// Each lane is written only when its mask bit is set. Read is combinational
// from the selected address. Assumes addresses below DEPTH.
module lanemask_ram_array #(
    parameter int DATA_W = 36,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 32,
    localparam int LANES  = DATA_W / LANE_W,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              lane_wr;

        // Lane write strobe: enabled edge, out of reset, lane selected.
        assign lane_wr = rst_n && en && wr_en && wr_lane[i];

        // Store this lane's slice of the write word.
        always_ff @(posedge clk) begin
            if (lane_wr) begin
                lane_mem[addr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        // Present this lane of the addressed word.
        assign stored[i*LANE_W +: LANE_W] = lane_mem[addr];

        // R1: an enabled lane holds the written slice after the edge.
        p_lane_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (en && wr_en && wr_lane[i]) |=>
                (lane_mem[$past(addr)] == $past(wdata[i*LANE_W +: LANE_W])));

        // R2: a masked lane keeps its old slice across a write.
        p_lane_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (en && wr_en && !wr_lane[i]) |=>
                (lane_mem[$past(addr)] == $past(stored[i*LANE_W +: LANE_W])));
    end
endmodule

// File: rtl/lanemask_ram_rdw.sv
// Read register with read-during-write selection.
// Loads the addressed word on an enabled read. During a write it loads the
// view chosen by RDW_MODE. With CLR_EN it clears asynchronously on clr.
module lanemask_ram_rdw
    import lanemask_ram_pkg::*;
#(
    parameter int        DATA_W   = 36,
    parameter int        LANE_W   = 9,
    parameter rdw_mode_e RDW_MODE = RDW_NEW_MERGED,
    parameter bit        CLR_EN   = 1'b0,
    localparam int       LANES    = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] zeroed;
    logic [DATA_W-1:0] wr_view;
    logic [DATA_W-1:0] q_next;
    logic              load;

    // Build the merged and zero-filled views of the word being written.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            merged[i*LANE_W +: LANE_W] = wr_lane[i] ? wdata[i*LANE_W +: LANE_W]
                                                    : stored[i*LANE_W +: LANE_W];
            zeroed[i*LANE_W +: LANE_W] = wr_lane[i] ? wdata[i*LANE_W +: LANE_W]
                                                    : '0;
        end
    end

    // Pick the view the mode returns during a write.
    if (RDW_MODE == RDW_NEW_MERGED) begin : g_merged
        assign wr_view = merged;
    end else if (RDW_MODE == RDW_NEW_MASKED_ZERO) begin : g_zeroed
        assign wr_view = zeroed;
    end else begin : g_oldword
        assign wr_view = stored;
    end

    assign q_next = wr_en ? wr_view : stored;
    assign load   = en && rd_en;

    if (CLR_EN) begin : g_clr
        // Read register with asynchronous clear.
        always_ff @(posedge clk or posedge clr) begin
            if (clr) begin
                q <= '0;
            end else if (!rst_n) begin
                q <= '0;
            end else if (load) begin
                q <= q_next;
            end
        end
    end else begin : g_noclr
        // Read register without clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load) begin
                q <= q_next;
            end
        end
    end

    // R4: no read enable, no change (a clear may zero it).
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rd_en && !clr) |=> ($stable(q) || (q == '0)));

    // R9: an idle edge leaves the read register alone.
    p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(q) || (q == '0)));
endmodule

// File: rtl/lanemask_ram_out.sv
// Optional output stage.
// OUT_REG=1 adds one enabled-edge register, cleared asynchronously when
// CLR_EN=1. OUT_REG=0 passes the read register straight through.
// Assumes clr spans at least one rising edge when raised.
module lanemask_ram_out #(
    parameter int DATA_W  = 36,
    parameter bit OUT_REG = 1'b1,
    parameter bit CLR_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    if (OUT_REG) begin : g_reg
        if (CLR_EN) begin : g_clr
            // Output register with asynchronous clear.
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    dout <= '0;
                end else if (!rst_n) begin
                    dout <= '0;
                end else if (en) begin
                    dout <= din;
                end
            end
        end else begin : g_noclr
            // Output register without clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dout <= '0;
                end else if (en) begin
                    dout <= din;
                end
            end
        end

        // R5: the output register trails the read register by one edge.
        p_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
            (en && !clr) |=> (dout == $past(din)));
    end else begin : g_pass
        // Unregistered: the read register is the output.
        assign dout = din;
    end

    // R11: a reset edge zeroes the output.
    p_rst_zero_r11: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));
endmodule

// File: rtl/lanemask_ram.sv
// Lane-masked single-port RAM with address hold, top level.
// Connects the address register, the lane array, the read register and the
// optional output register. Assumes DATA_W is a multiple of LANE_W.
module lanemask_ram
    import lanemask_ram_pkg::*;
#(
    parameter int        DATA_W   = 36,
    parameter int        LANE_W   = 9,
    parameter int        DEPTH    = 32,
    parameter rdw_mode_e RDW_MODE = RDW_NEW_MERGED,
    parameter bit        OUT_REG  = 1'b1,
    parameter bit        OUT_CLR  = 1'b1,
    localparam int       LANES    = DATA_W / LANE_W,
    localparam int       ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  wr_lane,
    input  logic              hold_addr,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] use_addr;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] q;

    // Reject lane sizes outside the supported set at elaboration.
    if (!(LANE_W == 5 || LANE_W == 8 || LANE_W == 9 || LANE_W == 10) ||
        (DATA_W % LANE_W) != 0) begin : g_bad_lane
        initial $error("lanemask_ram: unsupported lane size or word width");
    end

    lanemask_ram_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hold_addr (hold_addr),
        .addr      (addr),
        .use_addr  (use_addr)
    );

    lanemask_ram_array #(.DATA_W(DATA_W), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .wr_lane (wr_lane),
        .addr    (use_addr),
        .wdata   (wdata),
        .stored  (stored)
    );

    lanemask_ram_rdw #(
        .DATA_W   (DATA_W),
        .LANE_W   (LANE_W),
        .RDW_MODE (RDW_MODE),
        .CLR_EN   (OUT_CLR && !OUT_REG)
    ) u_rdw (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (en),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_lane (wr_lane),
        .wdata   (wdata),
        .stored  (stored),
        .q       (q)
    );

    lanemask_ram_out #(
        .DATA_W  (DATA_W),
        .OUT_REG (OUT_REG),
        .CLR_EN  (OUT_CLR && OUT_REG)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (en),
        .din   (q),
        .dout  (rdata)
    );

    if (OUT_CLR) begin : g_clr_chk
        // R10: while clear is high the output reads zero.
        p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            clr |-> (rdata == '0));
    end
endmodule

// File: tb/lanemask_ram_test.sv
// Self-checking bench: one table walk plus directed reset, idle and clear tests.
// Drives three instances that share every input: merged mode with a registered
// output, zero-fill mode unregistered, and old-word mode unregistered.
module lanemask_ram_test;
    import lanemask_ram_pkg::*;

    localparam int DW = 36;
    localparam int LW = 9;
    localparam int NL = DW / LW;
    localparam int AW = 5;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic          clr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [NL-1:0] wr_lane = '0;
    logic          hold_addr = 1'b0;
    logic [DW-1:0] rd_m, rd_z, rd_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Shadow state computed from the requirements.
    logic [DW-1:0] m_mem [32];
    logic [AW-1:0] m_areg;
    logic [DW-1:0] m_qm, m_qz, m_qo, m_dout;
    int            prev_tag;

    always #4 clk = ~clk;

    lanemask_ram uut (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .wr_lane(wr_lane), .hold_addr(hold_addr),
        .rdata(rd_m));

    lanemask_ram #(.RDW_MODE(RDW_NEW_MASKED_ZERO), .OUT_REG(1'b0)) uut_z (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .wr_lane(wr_lane), .hold_addr(hold_addr),
        .rdata(rd_z));

    lanemask_ram #(.RDW_MODE(RDW_OLD_WORD), .OUT_REG(1'b0)) uut_o (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .wr_lane(wr_lane), .hold_addr(hold_addr),
        .rdata(rd_o));

    // Layout: tag[51:48] wr[47] rd[46] hold[45] lanes[44:41] addr[40:36] data[35:0]
    localparam logic [51:0] VEC [NV] = '{
        {4'd4, 1'b1, 1'b0, 1'b0, 4'b1111, 5'd3, 36'h123456789},
        {4'd4, 1'b1, 1'b0, 1'b0, 4'b1111, 5'd7, 36'hF0F0F0F0F},
        {4'd4, 1'b1, 1'b0, 1'b0, 4'b1111, 5'd9, 36'h011112222},
        {4'd4, 1'b1, 1'b0, 1'b0, 4'b1111, 5'd0, 36'h888888888},
        {4'd5, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd3, 36'h000000000},
        {4'd6, 1'b1, 1'b1, 1'b0, 4'b0101, 5'd3, 36'hABCDEF012},
        {4'd2, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd3, 36'h000000000},
        {4'd5, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd7, 36'h000000000},
        {4'd3, 1'b0, 1'b1, 1'b1, 4'b0000, 5'd9, 36'h000000000},
        {4'd3, 1'b1, 1'b1, 1'b1, 4'b1000, 5'd9, 36'h555555555},
        {4'd1, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd7, 36'h000000000},
        {4'd3, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd9, 36'h000000000},
        {4'd6, 1'b1, 1'b1, 1'b0, 4'b1010, 5'd3, 36'h333333333},
        {4'd4, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd7, 36'h000000000},
        {4'd1, 1'b1, 1'b0, 1'b0, 4'b0001, 5'd9, 36'h777777777},
        {4'd1, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd9, 36'h000000000},
        {4'd2, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd3, 36'h000000000}
    };

    function automatic string tag_name(input int t, input int unit_sel);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return (unit_sel == 0) ? "R6" : ((unit_sel == 1) ? "R7" : "R8");
            9:  return "R9";
            10: return "R10";
            11: return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string unit_name, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, unit_name, act, exp);
        end
    endtask

    task automatic check_all(input int tg);
        check("uut", tag_name(prev_tag, 0), rd_m, m_dout);
        check("uut_z", tag_name(tg, 1), rd_z, m_qz);
        check("uut_o", tag_name(tg, 2), rd_o, m_qo);
    endtask

    // One access: drive at the falling edge, update the shadow, check after the rising edge.
    task automatic step(input logic c, input logic w, input logic r, input logic s,
                        input logic [NL-1:0] b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int tg);
        logic [AW-1:0] eff;
        logic [DW-1:0] old, mrg, zer;
        en = c; wr_en = w; rd_en = r; hold_addr = s; wr_lane = b; addr = a; wdata = d;
        eff = s ? m_areg : a;
        old = m_mem[eff];
        for (int i = 0; i < NL; i++) begin
            mrg[i*LW +: LW] = b[i] ? d[i*LW +: LW] : old[i*LW +: LW];
            zer[i*LW +: LW] = b[i] ? d[i*LW +: LW] : '0;
        end
        if (c) begin
            m_dout = m_qm;
            if (r) begin
                if (w) begin
                    m_qm = mrg; m_qz = zer; m_qo = old;
                end else begin
                    m_qm = old; m_qz = old; m_qo = old;
                end
            end
            if (w) m_mem[eff] = mrg;
            m_areg = eff;
        end
        @(posedge clk);
        #2;
        check_all(tg);
        prev_tag = tg;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #1600000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        m_areg = '0; m_qm = '0; m_qz = '0; m_qo = '0; m_dout = '0;
        prev_tag = 11;

        // R11: reset state of every output.
        repeat (3) @(posedge clk);
        #2;
        check_all(11);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: writes, reads, held addresses, partial lanes, read-during-write.
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][47], VEC[i][46], VEC[i][45], VEC[i][44:41],
                 VEC[i][40:36], VEC[i][35:0], int'(VEC[i][51:48]));
        end
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd0, '0, 5);

        // R9: idle edges block a write and keep every output.
        step(1'b0, 1'b1, 1'b1, 1'b0, 4'b1111, 5'd3, 36'hDEADBEEF0, 9);
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 5'd9, 36'h0BADC0DE1, 9);
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd3, '0, 9);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd3, '0, 9);

        // R10: asynchronous clear of the output stage, held across one edge.
        en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; hold_addr = 1'b0;
        #1;
        clr = 1'b1;
        #1;
        m_dout = '0; m_qz = '0; m_qo = '0;
        prev_tag = 10;
        check_all(10);
        @(posedge clk);
        #2;
        check_all(10);
        @(negedge clk);
        clr = 1'b0;
        #1;
        check_all(10);
        @(negedge clk);
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd7, '0, 5);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd7, '0, 5);

        // R11: a second reset clears the address register; a held read uses address 0.
        rst_n = 1'b0;
        en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; hold_addr = 1'b0;
        @(posedge clk);
        #2;
        m_dout = '0; m_qm = '0; m_qz = '0; m_qo = '0; m_areg = '0;
        prev_tag = 11;
        check_all(11);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 5'd9, '0, 11);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd9, '0, 11);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule